// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Slave

This block models the command side of a small serial EEPROM that stores 16-bit words. A host drives a chip select, a serial clock and a data input. The block answers on a data output that comes with its own output-enable. The serial pins are synchronised into the system clock domain, and serial-clock rising edges are detected there.

Each command opens with a start bit. It continues with a two-bit opcode and an address field of parameterised width, which is followed by data when the command needs it. Reads stream words out from an internal register array, and the address advances on its own. Writes go through a self-timed programming cycle. That cycle begins when chip select falls, and a cycle counter sets its length. While chip select is high after a write, the data output reports busy or ready.

A write-enable latch gates programming, together with a program-enable input. On a board without a program-enable control, that input should be tied high.

Top module: `mw_eeprom`

## Requirements
- R1: After reset the write-enable latch is clear, every word reads 0, and the output-enable is low. A WRITE issued before any enable command leaves memory unchanged and shows no status.
- R2: While waiting for a command, data-in bits of 0 sampled on serial-clock rises are ignored. The first 1 is taken as the start bit, so "0001" followed by an opcode behaves like "1" followed by the same opcode.
- R3: Opcode 10 is READ. After the last address bit, data-out drives one dummy 0 and then the 16 bits of the addressed word, MSB first, each on a serial-clock rise.
- R4: Opcode 01 is WRITE. It takes 16 data bits, MSB first. If chip select falls right after the 16th bit while the latch is set and program-enable is high, the word is stored once the programming cycle ends.
- R5: Opcode 00 with the two top address bits 11 sets the write-enable latch, and with 00 clears it. Once the latch is clear, WRITE leaves memory unchanged.
- R6: When program-enable is low, WRITE, latch-set and latch-clear commands have no effect.
- R7: Opcode 00 with the two top address bits 01 is reserved. Its data is ignored and memory is unchanged.
- R8: If the serial clock keeps running past 16 read bits, READ continues with the next word and no extra dummy bit. The address wraps from the top word to word 0.
- R9: Whenever chip select is low, the output-enable is low.
- R10: After an accepted write, raising chip select shows data-out 0 while programming and 1 once ready. This status ends, and the output-enable drops, when the next start bit is accepted.
- R11: If chip select falls before a WRITE is complete, or if a serial-clock rise arrives after the 16th data bit, memory is unchanged and no programming starts.
- R12: Commands started while programming is in progress are ignored, and the busy status stays on data-out.
- R13: Programming lasts PROG_CYCLES system clocks from the chip-select fall. Busy clears in the same cycle that the word is committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock; bits are sampled on its rising edge |
| di_i | input | 1 | Serial data in |
| pe_i | input | 1 | Program enable; tie high when unused |
| do_o | output | 1 | Serial data out or busy/ready status |
| do_oe_o | output | 1 | Output enable for do_o (low means high impedance) |

## Verification
READ is tried on a fresh word and on written words. It is also tried with leading zeros before the start bit, which tells a scanner that hunts for the start bit apart from one that takes the first bit as start. A long read over the top address shows whether words chain without a second dummy bit and whether the address wraps to 0.

WRITE is tried in several conditions, each compared with a read-back and with the status output: with the latch set and clear, with program-enable low, truncated, overrun by one bit, and issued while busy. This separates the gating by the latch from the gating by the program-enable pin, and both from the framing rules. The reserved write-all pattern is checked so that it cannot pass for a write.

// File: rtl/mw_pkg.sv
package mw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPC,
      ST_ADDR,
      ST_WDATA,
      ST_WDONE,
      ST_RDATA,
      ST_HOLD
   } mw_state_t;

   localparam logic [1:0] OPC_READ    = 2'b10;
   localparam logic [1:0] OPC_WRITE   = 2'b01;
   localparam logic [1:0] OPC_SPECIAL = 2'b00;

   localparam logic [1:0] SUB_LATCH_SET = 2'b11;
   localparam logic [1:0] SUB_LATCH_CLR = 2'b00;
   localparam logic [1:0] SUB_RESERVED  = 2'b01;

endpackage

// File: rtl/mw_sync_edge.sv
module mw_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);

   logic prev_q;

   generate
      if (STAGES == 0) begin : g_direct
         assign level_o = async_i;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], async_i};
         end
         assign level_o = chain_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level_o;
   end

   assign rise_o = level_o & ~prev_q;
   assign fall_o = ~level_o & prev_q;

endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
   parameter int CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o,
   output logic done_o
);

   localparam int CNT_W = $clog2(CYCLES + 1);

   logic [CNT_W-1:0] cnt_q;

   assign done_o = busy_o && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         cnt_q  <= '0;
      end else if (start_i && !busy_o) begin
         busy_o <= 1'b1;
         cnt_q  <= CNT_W'(CYCLES - 1);
      end else if (done_o) begin
         busy_o <= 1'b0;
      end else if (busy_o) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/mw_word_array.sv
module mw_word_array #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [ADDR_W-1:0] raddr_i,
   output logic [DATA_W-1:0] rdata_o
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] words_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) words_q[i] <= '0;
      end else if (we_i) begin
         words_q[waddr_i] <= wdata_i;
      end
   end

   assign rdata_o = words_q[raddr_i];

endmodule

// File: rtl/mw_cmd_engine.sv
module mw_cmd_engine
   import mw_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_s_i,
   input  logic              cs_fall_i,
   input  logic              sk_rise_i,
   input  logic              di_s_i,
   input  logic              pe_s_i,
   input  logic              busy_i,
   input  logic [DATA_W-1:0] rdata_i,
   output logic [ADDR_W-1:0] raddr_o,
   output logic              prog_start_o,
   output logic [ADDR_W-1:0] prog_addr_o,
   output logic [DATA_W-1:0] prog_data_o,
   output logic              wel_o,
   output logic              rd_active_o,
   output logic              status_en_o,
   output logic              do_o,
   output logic              do_oe_o
);

   localparam int MAXF  = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
   localparam int CNT_W = $clog2(MAXF);
   localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

   mw_state_t         state_q;
   logic [1:0]        opc_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [ADDR_W-1:0] sh_addr_q;
   logic [DATA_W-1:0] sh_data_q;
   logic [ADDR_W-1:0] rd_addr_q;
   logic [BIT_W-1:0]  bit_q;
   logic              do_bit_q;
   logic [ADDR_W-1:0] full_addr;
   logic [1:0]        sub_cmd;
   logic              accept_prog;

   assign full_addr    = {sh_addr_q[ADDR_W-2:0], di_s_i};
   assign sub_cmd      = full_addr[ADDR_W-1 -: 2];
   assign raddr_o      = rd_addr_q;
   assign rd_active_o  = (state_q == ST_RDATA);
   assign accept_prog  = cs_fall_i && (state_q == ST_WDONE) && wel_o && pe_s_i && !busy_i;
   assign prog_start_o = accept_prog;

   // serial command sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         opc_q     <= '0;
         cnt_q     <= '0;
         sh_addr_q <= '0;
         sh_data_q <= '0;
         rd_addr_q <= '0;
         bit_q     <= '0;
         do_bit_q  <= 1'b0;
         wel_o     <= 1'b0;
      end else if (!cs_s_i) begin
         state_q <= ST_IDLE;
      end else if (sk_rise_i) begin
         unique case (state_q)
            ST_IDLE: begin
               if (di_s_i && !busy_i) begin
                  state_q <= ST_OPC;
                  cnt_q   <= '0;
               end
            end
            ST_OPC: begin
               opc_q <= {opc_q[0], di_s_i};
               if (cnt_q == CNT_W'(1)) begin
                  state_q <= ST_ADDR;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_ADDR: begin
               sh_addr_q <= full_addr;
               if (cnt_q == CNT_W'(ADDR_W - 1)) begin
                  cnt_q <= '0;
                  case (opc_q)
                     OPC_READ: begin
                        state_q   <= ST_RDATA;
                        rd_addr_q <= full_addr;
                        bit_q     <= '0;
                        do_bit_q  <= 1'b0;
                     end
                     OPC_WRITE: begin
                        state_q <= ST_WDATA;
                     end
                     OPC_SPECIAL: begin
                        state_q <= ST_HOLD;
                        if (pe_s_i) begin
                           if (sub_cmd == SUB_LATCH_SET)      wel_o <= 1'b1;
                           else if (sub_cmd == SUB_LATCH_CLR) wel_o <= 1'b0;
                        end
                     end
                     default: state_q <= ST_HOLD;
                  endcase
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_WDATA: begin
               sh_data_q <= {sh_data_q[DATA_W-2:0], di_s_i};
               if (cnt_q == CNT_W'(DATA_W - 1)) state_q <= ST_WDONE;
               else                             cnt_q   <= cnt_q + 1'b1;
            end
            ST_WDONE: begin
               state_q <= ST_HOLD;
            end
            ST_RDATA: begin
               do_bit_q <= rdata_i[BIT_W'(DATA_W - 1) - bit_q];
               if (bit_q == BIT_W'(DATA_W - 1)) begin
                  bit_q     <= '0;
                  rd_addr_q <= rd_addr_q + 1'b1;
               end else begin
                  bit_q <= bit_q + 1'b1;
               end
            end
            default: state_q <= ST_HOLD;
         endcase
      end
   end

   // programming target and status window
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prog_addr_o <= '0;
         prog_data_o <= '0;
         status_en_o <= 1'b0;
      end else if (accept_prog) begin
         prog_addr_o <= sh_addr_q;
         prog_data_o <= sh_data_q;
         status_en_o <= 1'b1;
      end else if (cs_s_i && sk_rise_i && state_q == ST_IDLE && di_s_i && !busy_i) begin
         status_en_o <= 1'b0;
      end
   end

   // registered pin drivers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         do_o    <= 1'b0;
         do_oe_o <= 1'b0;
      end else begin
         do_oe_o <= cs_s_i && (rd_active_o || status_en_o);
         do_o    <= status_en_o ? ~busy_i : do_bit_q;
      end
   end

endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 16,
   parameter int PROG_CYCLES = 1000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_i,
   input  logic sk_i,
   input  logic di_i,
   input  logic pe_i,
   output logic do_o,
   output logic do_oe_o
);

   generate
      if (ADDR_W < 2 || ADDR_W > 12) begin : g_bad_addr
         $error("mw_eeprom: ADDR_W must lie in 2..12");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("mw_eeprom: DATA_W must be at least 2");
      end
      if (PROG_CYCLES < 1) begin : g_bad_prog
         $error("mw_eeprom: PROG_CYCLES must be positive");
      end
      if (SYNC_STAGES == 1 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("mw_eeprom: SYNC_STAGES must be 0, 2, 3 or 4");
      end
   endgenerate

   logic              cs_s, cs_rise, cs_fall;
   logic              sk_s, sk_rise, sk_fall;
   logic              di_s, di_rise, di_fall;
   logic              pe_s, pe_rise, pe_fall;
   logic              busy, mem_we;
   logic              prog_start, wel, rd_active, status_en;
   logic [ADDR_W-1:0] raddr, prog_addr;
   logic [DATA_W-1:0] rdata, prog_data;

   mw_sync_edge #(.STAGES(SYNC_STAGES)) i_sync_cs (
      .clk(clk), .rst_n(rst_n), .async_i(cs_i),
      .level_o(cs_s), .rise_o(cs_rise), .fall_o(cs_fall));

   mw_sync_edge #(.STAGES(SYNC_STAGES)) i_sync_sk (
      .clk(clk), .rst_n(rst_n), .async_i(sk_i),
      .level_o(sk_s), .rise_o(sk_rise), .fall_o(sk_fall));

   mw_sync_edge #(.STAGES(SYNC_STAGES)) i_sync_di (
      .clk(clk), .rst_n(rst_n), .async_i(di_i),
      .level_o(di_s), .rise_o(di_rise), .fall_o(di_fall));

   mw_sync_edge #(.STAGES(SYNC_STAGES)) i_sync_pe (
      .clk(clk), .rst_n(rst_n), .async_i(pe_i),
      .level_o(pe_s), .rise_o(pe_rise), .fall_o(pe_fall));

   mw_cmd_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_engine (
      .clk(clk), .rst_n(rst_n),
      .cs_s_i(cs_s), .cs_fall_i(cs_fall), .sk_rise_i(sk_rise),
      .di_s_i(di_s), .pe_s_i(pe_s), .busy_i(busy),
      .rdata_i(rdata), .raddr_o(raddr),
      .prog_start_o(prog_start), .prog_addr_o(prog_addr), .prog_data_o(prog_data),
      .wel_o(wel), .rd_active_o(rd_active), .status_en_o(status_en),
      .do_o(do_o), .do_oe_o(do_oe_o));

   mw_prog_timer #(.CYCLES(PROG_CYCLES)) i_timer (
      .clk(clk), .rst_n(rst_n), .start_i(prog_start),
      .busy_o(busy), .done_o(mem_we));

   mw_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_array (
      .clk(clk), .rst_n(rst_n), .we_i(mem_we),
      .waddr_i(prog_addr), .wdata_i(prog_data),
      .raddr_i(raddr), .rdata_o(rdata));

endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk (
   input logic clk,
   input logic rst_n,
   input logic cs_s,
   input logic cs_fall,
   input logic do_oe_o,
   input logic busy,
   input logic mem_we,
   input logic wel,
   input logic rd_active,
   input logic status_en
);

   // R9
   cs_low_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_s |=> !do_oe_o);

   // R4
   prog_from_cs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cs_fall));

   // R5
   prog_needs_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wel));

   // R13
   commit_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !busy);

   // R13
   busy_ends_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(mem_we));

   // R10
   status_read_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_active, status_en}));

endmodule

bind mw_eeprom mw_eeprom_chk i_chk (
   .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .cs_fall(cs_fall),
   .do_oe_o(do_oe_o), .busy(busy), .mem_we(mem_we), .wel(wel),
   .rd_active(rd_active), .status_en(status_en));

// File: tb/test_mw_eeprom.sv
module test_mw_eeprom;

   localparam int AW   = 8;
   localparam int DW   = 16;
   localparam int PROG = 600;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs = 1'b0, sk = 1'b0, di = 1'b0, pe = 1'b1;
   logic do_w, oe_w;
   int   n_chk = 0, n_fail = 0;
   bit   finished = 1'b0;

   always #2 clk = ~clk;

   mw_eeprom #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PROG), .SYNC_STAGES(2)) i_mw_eeprom (
      .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di), .pe_i(pe),
      .do_o(do_w), .do_oe_o(oe_w));

   task automatic check(input string req, input string what, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clk_bit(input logic b, output logic o, output logic oe);
      di = b;
      idle(8);
      sk = 1'b1;
      idle(6);
      o  = do_w;
      oe = oe_w;
      idle(2);
      sk = 1'b0;
   endtask

   task automatic cs_on;
      cs = 1'b1;
      idle(8);
   endtask

   task automatic cs_off;
      idle(8);
      cs = 1'b0;
      idle(8);
   endtask

   task automatic send_hdr(input logic [1:0] op, input logic [AW-1:0] a, output logic last);
      logic oe;
      clk_bit(1'b1, last, oe);
      clk_bit(op[1], last, oe);
      clk_bit(op[0], last, oe);
      for (int i = AW - 1; i >= 0; i--) clk_bit(a[i], last, oe);
   endtask

   task automatic send_word(input logic [DW-1:0] d);
      logic o, oe;
      for (int i = DW - 1; i >= 0; i--) clk_bit(d[i], o, oe);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      logic l;
      cs_on();
      send_hdr(2'b01, a, l);
      send_word(d);
      cs_off();
   endtask

   task automatic special(input logic [AW-1:0] a);
      logic l;
      cs_on();
      send_hdr(2'b00, a, l);
      cs_off();
   endtask

   task automatic wait_ready;
      int k;
      cs_on();
      k = 0;
      while (!(oe_w && do_w) && k < 4 * PROG) begin
         idle(1);
         k++;
      end
      check("R10", "ready seen", 32'(k < 4 * PROG), 1);
      cs_off();
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic dummy);
      logic o, oe;
      cs_on();
      send_hdr(2'b10, a, dummy);
      for (int i = DW - 1; i >= 0; i--) begin
         clk_bit(1'b0, o, oe);
         d[i] = o;
      end
      cs_off();
   endtask

   task automatic t_reset;
      logic [DW-1:0] d;
      logic dm;
      check("R1", "oe after reset", 32'(oe_w), 0);
      wr(8'h05, 16'hFFFF);
      cs_on();
      check("R1", "no status without latch", 32'(oe_w), 0);
      cs_off();
      rd(8'h05, d, dm);
      check("R1", "word unchanged", 32'(d), 0);
   endtask

   task automatic t_write_read;
      logic [DW-1:0] d;
      logic dm;
      special(8'hC0);
      wr(8'h12, 16'hA5C3);
      cs_on();
      idle(20);
      check("R13", "busy oe", 32'(oe_w), 1);
      check("R13", "busy level", 32'(do_w), 0);
      cs_off();
      idle(PROG);
      cs_on();
      check("R10", "ready level", 32'(do_w), 1);
      cs_off();
      check("R9", "oe with cs low", 32'(oe_w), 0);
      rd(8'h12, d, dm);
      check("R3", "dummy bit", 32'(dm), 0);
      check("R4", "written word", 32'(d), 32'hA5C3);
   endtask

   task automatic t_leading_zero;
      logic o, oe, l;
      logic [DW-1:0] d;
      cs_on();
      clk_bit(1'b0, o, oe);
      clk_bit(1'b0, o, oe);
      clk_bit(1'b0, o, oe);
      send_hdr(2'b10, 8'h12, l);
      for (int i = DW - 1; i >= 0; i--) begin
         clk_bit(1'b0, o, oe);
         d[i] = o;
      end
      cs_off();
      check("R2", "read after zeros", 32'(d), 32'hA5C3);
   endtask

   task automatic t_status_end;
      logic o, oe;
      wr(8'h20, 16'h1111);
      cs_on();
      while (!do_w) idle(1);
      check("R10", "status oe before start", 32'(oe_w), 1);
      clk_bit(1'b1, o, oe);
      check("R10", "oe after start bit", 32'(oe), 0);
      cs_off();
   endtask

   task automatic t_busy_ignore;
      logic [DW-1:0] d;
      logic dm;
      wr(8'h22, 16'h3333);
      wr(8'h21, 16'h2222);
      cs_on();
      check("R12", "status still shown", 32'(oe_w), 1);
      cs_off();
      wait_ready();
      rd(8'h21, d, dm);
      check("R12", "busy write dropped", 32'(d), 0);
      rd(8'h22, d, dm);
      check("R4", "first write kept", 32'(d), 32'h3333);
   endtask

   task automatic t_disable;
      logic [DW-1:0] d;
      logic dm;
      special(8'h00);
      wr(8'h12, 16'h0000);
      cs_on();
      check("R5", "no status after disable", 32'(oe_w), 0);
      cs_off();
      rd(8'h12, d, dm);
      check("R5", "word kept", 32'(d), 32'hA5C3);
   endtask

   task automatic t_pe;
      logic [DW-1:0] d;
      logic dm;
      special(8'hC0);
      pe = 1'b0;
      wr(8'h30, 16'hBEEF);
      special(8'h00);
      pe = 1'b1;
      rd(8'h30, d, dm);
      check("R6", "write with pe low", 32'(d), 0);
      wr(8'h30, 16'hBEEF);
      wait_ready();
      rd(8'h30, d, dm);
      check("R6", "disable with pe low ignored", 32'(d), 32'hBEEF);
      special(8'h00);
      pe = 1'b0;
      special(8'hC0);
      pe = 1'b1;
      wr(8'h31, 16'h7777);
      rd(8'h31, d, dm);
      check("R6", "enable with pe low ignored", 32'(d), 0);
   endtask

   task automatic t_reserved;
      logic [DW-1:0] d;
      logic dm, l;
      special(8'hC0);
      cs_on();
      send_hdr(2'b00, 8'h40, l);
      send_word(16'h5A5A);
      cs_off();
      cs_on();
      check("R7", "no status", 32'(oe_w), 0);
      cs_off();
      rd(8'h12, d, dm);
      check("R7", "memory kept", 32'(d), 32'hA5C3);
   endtask

   task automatic t_wrap;
      logic o, oe, l;
      logic [DW-1:0] d0, d1;
      wr(8'hFF, 16'hCAFE);
      wait_ready();
      wr(8'h00, 16'h1234);
      wait_ready();
      cs_on();
      send_hdr(2'b10, 8'hFF, l);
      for (int i = DW - 1; i >= 0; i--) begin
         clk_bit(1'b0, o, oe);
         d0[i] = o;
      end
      for (int i = DW - 1; i >= 0; i--) begin
         clk_bit(1'b0, o, oe);
         d1[i] = o;
      end
      cs_off();
      check("R8", "top word", 32'(d0), 32'hCAFE);
      check("R8", "wrapped word", 32'(d1), 32'h1234);
   endtask

   task automatic t_abort;
      logic [DW-1:0] d;
      logic dm, l, o, oe;
      cs_on();
      send_hdr(2'b01, 8'h40, l);
      for (int i = 0; i < 8; i++) clk_bit(1'b1, o, oe);
      cs_off();
      cs_on();
      check("R11", "no status on short write", 32'(oe_w), 0);
      cs_off();
      cs_on();
      send_hdr(2'b01, 8'h41, l);
      send_word(16'h9999);
      clk_bit(1'b1, o, oe);
      cs_off();
      rd(8'h40, d, dm);
      check("R11", "short write dropped", 32'(d), 0);
      rd(8'h41, d, dm);
      check("R11", "overrun write dropped", 32'(d), 0);
   endtask

   initial begin
      idle(5);
      rst_n = 1'b1;
      idle(10);
      t_reset();
      t_write_read();
      t_leading_zero();
      t_status_end();
      t_busy_ignore();
      t_disable();
      t_pe();
      t_reserved();
      t_wrap();
      t_abort();
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule